// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns a stream of bytes into frames on a single asynchronous serial line. Bytes enter through a valid/ready write port and wait in an eight-entry first-in first-out queue. A frame shifter drains the queue one byte at a time. Each frame has a low start bit, eight data bits sent least-significant first, no parity bit, and one or two high stop bits.

The bit period is set by a divisor input, given as a count of clock cycles. The stop-bit count is chosen per frame through a select input. The queue reports its occupancy, a full flag and an empty flag. It also raises a refill flag while the occupancy is below a threshold that software sets. Driver code uses this flag to top up the queue before the line runs dry. Frames taken from a non-empty queue follow one another with no idle time between them.

Top module: `serial_tx_queue`

## Requirements
- R1: After reset the serial output is high, the queue is empty (`q_empty` = 1, `q_full` = 0, `q_level` = 0) and `wr_ready` is 1.
- R2: The serial output stays high whenever no frame is being sent.
- R3: A frame begins with a low start bit lasting one bit period, followed by the eight data bits, bit 0 first, each lasting one bit period.
- R4: After the data bits the line is high for one stop bit when `two_stop` = 0 and for two stop bits when `two_stop` = 1, with no parity bit.
- R5: `two_stop` is sampled in the cycle a frame is taken from the queue and governs that whole frame; later changes affect only later frames.
- R6: When the queue still holds data at the end of the final stop bit, the next start bit begins in the very next cycle, so frame starts are exactly 10 (or 11) bit periods apart.
- R7: The queue holds up to 8 bytes; `q_level` gives the number held, `q_full` is 1 exactly at 8 and `q_empty` is 1 exactly at 0.
- R8: While the queue holds 8 bytes `wr_ready` is 0, and a write presented then is dropped and never transmitted.
- R9: `refill` is 1 exactly when `q_level` is strictly less than `refill_at`, both read as unsigned numbers; a threshold of 0 keeps it low and a threshold of 8 keeps it high unless the queue is full.
- R10: One bit period lasts `bit_div` clock cycles for any `bit_div` of 1 or more; a value of 0 acts as 1.
- R11: Bytes leave in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_data | input | 8 | Byte to queue |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Queue can accept a byte |
| two_stop | input | 1 | 1 selects two stop bits, 0 selects one |
| refill_at | input | 4 | Refill threshold, 0 to 8 |
| bit_div | input | 16 | Bit period in clock cycles |
| ser_out | output | 1 | Serial line |
| q_full | output | 1 | Queue holds 8 bytes |
| q_empty | output | 1 | Queue holds no bytes |
| q_level | output | 4 | Number of bytes in the queue |
| refill | output | 1 | Occupancy below threshold |

## Verification
The embedded assertions watch the cycle-level invariants on every clock. These cover the line value during idle, the start bit and the stop bits, and the occupancy moving by at most one per cycle. They also check that a full queue stays full until a byte is taken, that nothing is read from an empty queue, and that the bit counter stays inside its divisor. Other behaviours only show up across a whole frame, so the bench scenarios check them. These are the decoded byte values and their bit order, the exact spacing between frame starts for each stop setting and divisor, the per-frame sampling of the stop select, the loss of a write made while the queue is full, and the refill flag swept against every threshold at every fill level.

// File: rtl/stx_pkg.sv
package stx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_START = 2'd1,
      ST_DATA  = 2'd2,
      ST_STOP  = 2'd3
   } stx_state_e;

   localparam int unsigned FRAME_OVERHEAD = 2;

endpackage

// File: rtl/stx_fifo.sv
module stx_fifo #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 8,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_valid,
   input  logic [DATA_W-1:0] push_data,
   output logic              push_ready,
   input  logic              pop,
   output logic [DATA_W-1:0] pop_data,
   output logic [LVL_W-1:0]  level,
   output logic              full,
   output logic              empty
);

   localparam logic [LVL_W-1:0] LVL_MAX  = LVL_W'(DEPTH);
   localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [PTR_W-1:0]  wr_ptr_nxt, rd_ptr_nxt;
   logic              push_fire, pop_fire;

   assign full       = (level == LVL_MAX);
   assign empty      = (level == '0);
   assign push_ready = !full;
   assign push_fire  = push_valid && !full;
   assign pop_fire   = pop && !empty;
   assign pop_data   = mem[rd_ptr];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
         assign wr_ptr_nxt = wr_ptr + PTR_W'(1);
         assign rd_ptr_nxt = rd_ptr + PTR_W'(1);
      end else begin : g_cmp_wrap
         assign wr_ptr_nxt = (wr_ptr == PTR_LAST) ? '0 : wr_ptr + PTR_W'(1);
         assign rd_ptr_nxt = (rd_ptr == PTR_LAST) ? '0 : rd_ptr + PTR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_fire) begin
         mem[wr_ptr] <= push_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push_fire) begin
            wr_ptr <= wr_ptr_nxt;
         end
         if (pop_fire) begin
            rd_ptr <= rd_ptr_nxt;
         end
         if (push_fire && !pop_fire) begin
            level <= level + LVL_W'(1);
         end else if (pop_fire && !push_fire) begin
            level <= level - LVL_W'(1);
         end
      end
   end

   // R7: occupancy moves by at most one entry per cycle and never passes DEPTH
   a_r7_level_step : assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((level == $past(level)) ||
                (level == $past(level) + LVL_W'(1)) ||
                (level + LVL_W'(1) == $past(level))));

   a_r7_level_bound : assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_MAX);

   // R8: a full queue stays full until something is taken out
   a_r8_full_holds : assert property (@(posedge clk) disable iff (!rst_n)
      (full && !pop) |=> full);

endmodule

// File: rtl/stx_baud.sv
module stx_baud #(
   parameter int unsigned DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] divisor,
   output logic             bit_end
);

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] div_eff;

   assign div_eff = (divisor == '0) ? DIV_W'(1) : divisor;
   assign bit_end = run && (cnt == div_eff - DIV_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run || bit_end) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + DIV_W'(1);
      end
   end

   // R10: the cycle counter never leaves the range of one bit period
   a_r10_cnt_range : assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt < div_eff));

endmodule

// File: rtl/stx_shifter.sv
module stx_shifter
   import stx_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   localparam int unsigned BIT_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              q_empty,
   input  logic [DATA_W-1:0] q_data,
   output logic              q_pop,
   input  logic              two_stop,
   input  logic              bit_end,
   output logic              baud_run,
   output logic              tx
);

   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

   stx_state_e        state;
   logic [DATA_W-1:0] shreg;
   logic [BIT_W-1:0]  bit_idx;
   logic              stop2_q;
   logic              stop_idx;
   logic              stop_last;
   logic              frame_done;

   assign stop_last  = !stop2_q || stop_idx;
   assign frame_done = (state == ST_STOP) && bit_end && stop_last;
   assign q_pop      = !q_empty && ((state == ST_IDLE) || frame_done);
   assign baud_run   = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         shreg    <= '0;
         bit_idx  <= '0;
         stop2_q  <= 1'b0;
         stop_idx <= 1'b0;
         tx       <= 1'b1;
      end else begin
         unique case (state)
            ST_IDLE: begin
               tx <= 1'b1;
               if (q_pop) begin
                  state   <= ST_START;
                  shreg   <= q_data;
                  stop2_q <= two_stop;
                  tx      <= 1'b0;
               end
            end
            ST_START: begin
               if (bit_end) begin
                  state   <= ST_DATA;
                  bit_idx <= '0;
                  tx      <= shreg[0];
               end
            end
            ST_DATA: begin
               if (bit_end) begin
                  if (bit_idx == BIT_LAST) begin
                     state    <= ST_STOP;
                     stop_idx <= 1'b0;
                     tx       <= 1'b1;
                  end else begin
                     shreg   <= shreg >> 1;
                     bit_idx <= bit_idx + BIT_W'(1);
                     tx      <= shreg[1];
                  end
               end
            end
            ST_STOP: begin
               if (bit_end) begin
                  if (!stop_last) begin
                     stop_idx <= 1'b1;
                  end else if (q_pop) begin
                     state    <= ST_START;
                     shreg    <= q_data;
                     stop2_q  <= two_stop;
                     tx       <= 1'b0;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R2: line is high while no frame is in flight
   a_r2_idle_high : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> tx);

   // R3: start bit is low for its whole duration
   a_r3_start_low : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_START) |-> !tx);

   // R4: stop bits are high
   a_r4_stop_high : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STOP) |-> tx);

   // R5: the stop selection of a frame changes only when a new frame is taken
   a_r5_sel_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !q_pop |=> $stable(stop2_q));

   // R6: nothing is taken from an empty queue
   a_r6_pop_legal : assert property (@(posedge clk) disable iff (!rst_n)
      q_pop |-> !q_empty);

endmodule

// File: rtl/serial_tx_queue.sv
module serial_tx_queue #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned DIV_W  = 16,
   localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_valid,
   output logic              wr_ready,
   input  logic              two_stop,
   input  logic [LVL_W-1:0]  refill_at,
   input  logic [DIV_W-1:0]  bit_div,
   output logic              ser_out,
   output logic              q_full,
   output logic              q_empty,
   output logic [LVL_W-1:0]  q_level,
   output logic              refill
);

   generate
      if (DATA_W < 2) begin : g_chk_data
         $error("serial_tx_queue: DATA_W must be at least 2");
      end
      if (DEPTH < 2) begin : g_chk_depth
         $error("serial_tx_queue: DEPTH must be at least 2");
      end
      if (DIV_W < 1) begin : g_chk_div
         $error("serial_tx_queue: DIV_W must be at least 1");
      end
   endgenerate

   logic [DATA_W-1:0] head_data;
   logic              pop;
   logic              bit_end;
   logic              baud_run;

   stx_fifo #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_fifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_valid (wr_valid),
      .push_data  (wr_data),
      .push_ready (wr_ready),
      .pop        (pop),
      .pop_data   (head_data),
      .level      (q_level),
      .full       (q_full),
      .empty      (q_empty)
   );

   stx_baud #(
      .DIV_W (DIV_W)
   ) u_baud (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (baud_run),
      .divisor (bit_div),
      .bit_end (bit_end)
   );

   stx_shifter #(
      .DATA_W (DATA_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .q_empty  (q_empty),
      .q_data   (head_data),
      .q_pop    (pop),
      .two_stop (two_stop),
      .bit_end  (bit_end),
      .baud_run (baud_run),
      .tx       (ser_out)
   );

   assign refill = (q_level < refill_at);

   // R9: a full queue never asks for a refill, an empty one does whenever the threshold is nonzero
   a_r9_refill_full : assert property (@(posedge clk) disable iff (!rst_n)
      q_full |-> !refill);

   a_r9_refill_empty : assert property (@(posedge clk) disable iff (!rst_n)
      (q_empty && (refill_at != '0)) |-> refill);

endmodule

// File: tb/serial_tx_queue_tb.sv
module serial_tx_queue_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  wr_data = '0;
   logic        wr_valid = 1'b0;
   logic        wr_ready;
   logic        two_stop = 1'b0;
   logic [3:0]  refill_at = '0;
   logic [15:0] bit_div = 16'd20;
   logic        ser_out;
   logic        q_full, q_empty, refill;
   logic [3:0]  q_level;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int div = 20;
   int nfr = 0;
   logic [7:0] got_data [64];
   int         got_t    [64];
   bit         done = 1'b0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   serial_tx_queue u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_data   (wr_data),
      .wr_valid  (wr_valid),
      .wr_ready  (wr_ready),
      .two_stop  (two_stop),
      .refill_at (refill_at),
      .bit_div   (bit_div),
      .ser_out   (ser_out),
      .q_full    (q_full),
      .q_empty   (q_empty),
      .q_level   (q_level),
      .refill    (refill)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   // frame decoder on the serial line
   initial begin
      @(posedge rst_n);
      forever begin
         @(negedge clk);
         if (ser_out === 1'b0) begin
            logic [7:0] b;
            int t0;
            t0 = cyc;
            repeat (div / 2) @(negedge clk);
            chk(ser_out === 1'b0, "R3 start bit low", int'(ser_out), 0);
            for (int i = 0; i < 8; i++) begin
               repeat (div) @(negedge clk);
               b[i] = ser_out;
            end
            repeat (div) @(negedge clk);
            chk(ser_out === 1'b1, "R4 stop bit high", int'(ser_out), 1);
            got_data[nfr] = b;
            got_t[nfr] = t0;
            nfr++;
         end
      end
   end

   task automatic put(input logic [7:0] d);
      @(negedge clk);
      wr_data  = d;
      wr_valid = 1'b1;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic sweep_refill(input int lvl);
      for (int thr = 0; thr <= 8; thr++) begin
         @(negedge clk);
         refill_at = 4'(thr);
         #1;
         chk(refill === (lvl < thr), "R9 refill vs threshold", int'(refill), int'(lvl < thr));
      end
   endtask

   task automatic wait_frames(input int n);
      while (nfr < n) @(negedge clk);
   endtask

   logic [7:0] fill [8] = '{8'h01, 8'h80, 8'h3C, 8'hFF, 8'h00, 8'h5A, 8'hC3, 8'h7E};

   initial begin
      repeat (3) @(negedge clk);
      #1;
      // R1: reset state
      chk(ser_out === 1'b1, "R1 line high in reset", int'(ser_out), 1);
      chk(q_empty === 1'b1, "R1 empty in reset", int'(q_empty), 1);
      chk(q_full === 1'b0, "R1 not full in reset", int'(q_full), 0);
      chk(q_level === 4'd0, "R1 level zero", int'(q_level), 0);
      chk(wr_ready === 1'b1, "R1 ready", int'(wr_ready), 1);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(ser_out === 1'b1, "R2 idle high after reset", int'(ser_out), 1);

      // first byte: one cycle in queue, then taken
      put(8'hA5);
      #1;
      chk(q_level === 4'd1, "R7 level after write", int'(q_level), 1);
      chk(q_empty === 1'b0, "R7 not empty", int'(q_empty), 0);
      @(negedge clk);
      #1;
      chk(q_level === 4'd0, "R7 level after take", int'(q_level), 0);
      chk(ser_out === 1'b0, "R3 start follows take", int'(ser_out), 0);
      sweep_refill(0);

      // fill the queue to the top, sweeping thresholds at each level
      for (int k = 1; k <= 8; k++) begin
         put(fill[k-1]);
         #1;
         chk(q_level === 4'(k), "R7 level count", int'(q_level), k);
         chk(q_full === (k == 8), "R7 full flag", int'(q_full), int'(k == 8));
         chk(q_empty === 1'b0, "R7 empty flag", int'(q_empty), 0);
         chk(wr_ready === (k < 8), "R8 ready vs level", int'(wr_ready), int'(k < 8));
         sweep_refill(k);
      end

      // R8: write while full is dropped
      @(negedge clk);
      wr_data  = 8'hEE;
      wr_valid = 1'b1;
      #1;
      chk(wr_ready === 1'b0, "R8 not ready when full", int'(wr_ready), 0);
      @(negedge clk);
      wr_valid = 1'b0;
      #1;
      chk(q_level === 4'd8, "R8 level unchanged", int'(q_level), 8);

      wait_frames(9);
      chk(got_data[0] === 8'hA5, "R3 first byte lsb first", int'(got_data[0]), 'hA5);
      for (int i = 1; i < 9; i++) begin
         chk(got_data[i] === fill[i-1], "R11 order and R3 bit order", int'(got_data[i]), int'(fill[i-1]));
      end
      for (int i = 0; i < 8; i++) begin
         chk(got_t[i+1] - got_t[i] == 10 * div, "R6 no gap one stop", got_t[i+1] - got_t[i], 10 * div);
      end
      repeat (40) @(negedge clk);
      begin
         bit hi;
         hi = 1'b1;
         repeat (60) begin
            @(negedge clk);
            if (ser_out !== 1'b1) hi = 1'b0;
         end
         chk(hi, "R2 idle high after drain", int'(hi), 1);
      end
      chk(nfr == 9, "R8 dropped byte never sent", nfr, 9);

      // R5: stop select sampled per frame
      put(8'h12);
      put(8'h34);
      put(8'h56);
      two_stop = 1'b1;
      wait_frames(12);
      chk(got_t[10] - got_t[9] == 10 * div, "R5 first frame keeps one stop", got_t[10] - got_t[9], 10 * div);
      chk(got_t[11] - got_t[10] == 11 * div, "R4 two stop bits", got_t[11] - got_t[10], 11 * div);
      chk(got_data[11] === 8'h56, "R11 third byte", int'(got_data[11]), 'h56);
      repeat (3 * div) @(negedge clk);
      two_stop = 1'b0;

      // R10: other divisors
      bit_div = 16'd3;
      div = 3;
      put(8'h96);
      put(8'h69);
      wait_frames(14);
      chk(got_data[12] === 8'h96, "R10 byte at divisor 3", int'(got_data[12]), 'h96);
      chk(got_data[13] === 8'h69, "R10 byte at divisor 3", int'(got_data[13]), 'h69);
      chk(got_t[13] - got_t[12] == 30, "R10 period at divisor 3", got_t[13] - got_t[12], 30);
      repeat (30) @(negedge clk);

      bit_div = 16'd1;
      div = 1;
      put(8'hD2);
      put(8'h2D);
      wait_frames(16);
      chk(got_data[14] === 8'hD2, "R10 byte at divisor 1", int'(got_data[14]), 'hD2);
      chk(got_data[15] === 8'h2D, "R10 byte at divisor 1", int'(got_data[15]), 'h2D);
      chk(got_t[15] - got_t[14] == 10, "R10 period at divisor 1", got_t[15] - got_t[14], 10);
      repeat (20) @(negedge clk);

      summary();
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      summary();
   end

endmodule